// File: doc/BRIEF.md
# Time-of-Day Clock with Atomic Set and Adjust

This block keeps a running nanosecond time with a 32-bit fractional part, a whole-second count, and a pair of boundaries that bracket the current second. On every clock cycle the time advances by a programmable step in 32.32 fixed-point nanoseconds. When the time reaches the upper boundary, the second count moves on by one and both boundaries shift up by one second (1,000,000,000 ns).

Software changes the time without racing the running counter. First it writes target or delta values into staging registers through a plain address/data write port. It then writes an operation code. On the next cycle the block applies that code to the live counter in a single edge:

- load the staged values as the new time;
- add the staged delta to the time;
- subtract the staged delta from the time.

The code then clears itself. An add or subtract also keeps the cycle's normal step, so no tick is lost, and it repairs the second count and the boundaries when the result crosses one second edge.

An external event strobe captures the current time in packed form: the low 32 bits of the second count in the upper word, and the nanoseconds past the current boundary in the lower word. A constant capability word reports in bit 0 that atomic update is present.

Top module: `tod_atomic_clock`

## Requirements
- R1: During reset and after it, before the first active edge, `now_ns`, `now_sec` and `evt_stamp` are 0. The upper boundary starts at 1,000,000,000 and the lower boundary at 0.
- R2: With no operation pending, every clock edge adds the step register (address 6; bits 63:32 whole ns, bits 31:0 fraction) to the time. The step after reset is 5.0 ns.
- R3: Fractional step bits accumulate and carry into whole nanoseconds. A step of 2.5 ns gives alternating advances of 2 and 3 ns, starting from a zero fraction.
- R4: When the advanced time is at or above the upper boundary, `now_sec` increases by one and the boundaries move up by 1,000,000,000.
- R5: The operation field is bits 28:26 of a write to address 0. Code 1 loads, code 3 adds and code 4 subtracts. The code is applied exactly once, on the edge after the write. Any other code only lets the normal step happen.
- R6: A load copies the staging registers into the live state on one edge. The staging registers are at these addresses: nanoseconds 1, fraction 2, seconds 3, upper boundary 4, lower boundary 5.
- R7: An add sets the time to old time + step + staged delta. If the result reaches the upper boundary, `now_sec` increments and the boundaries move up.
- R8: A subtract sets the time to old time + step − staged delta. If the result falls below the lower boundary, `now_sec` decrements and the boundaries move down by one second.
- R9: A subtract whose result would be negative leaves the time at exactly 0.
- R10: A cycle with `evt_strobe` high captures the time of that cycle, before the edge, into `evt_stamp`. The upper word holds seconds and the lower word holds nanoseconds past the lower boundary, so seconds×1e9 + low equals the time.
- R11: Bit 0 of `cap_bits` is 1.
- R12: Writes to the staging registers without an operation code leave the live time running at its step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 64 | Register write data |
| evt_strobe | input | 1 | External event capture request |
| now_ns | output | NS_W | Live nanosecond time |
| now_sec | output | SEC_W | Live second count |
| evt_stamp | output | 64 | Last captured event time, packed seconds/nanoseconds |
| cap_bits | output | 64 | Capability word, bit 0 = atomic update |

## Verification
Whole-nanosecond steps check the exact tick against a 2.5 ns step. The 2.5 ns step shows whether the fractional carry is kept or dropped.

Loads placed a few ticks below a second edge separate a correct rollover from an off-by-one compare. Adds and subtracts that cross an edge in each direction show whether the boundaries are repaired as well as the time. A subtract larger than the time isolates saturation from wraparound.

A seeded random mix of loads, adds and subtracts checks the time exactly and checks that the second count always equals the time divided by one second. A second reading one cycle after each operation catches a code that fails to clear.

// File: rtl/tod_atomic_clock.sv
`timescale 1ns/1ps
module tod_atomic_clock #(
  parameter int          NS_W     = 64,
  parameter int          FRAC_W   = 32,
  parameter int          SEC_W    = 64,
  parameter int          STEP_W   = 64,
  parameter logic [63:0] ROLL_NS  = 64'd1_000_000_000,
  parameter logic [63:0] STEP_RST = 64'h0000_0005_0000_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [63:0]       wr_data,
  input  logic              evt_strobe,
  output logic [NS_W-1:0]   now_ns,
  output logic [SEC_W-1:0]  now_sec,
  output logic [63:0]       evt_stamp,
  output logic [63:0]       cap_bits
);
  localparam int ACC_W = NS_W + FRAC_W;
  localparam logic [NS_W-1:0] ROLL = NS_W'(ROLL_NS);
  localparam logic [2:0] OP_SET = 3'd1, OP_INC = 3'd3, OP_DEC = 3'd4;
  localparam logic [2:0] A_CTRL = 3'd0, A_NS = 3'd1, A_FRAC = 3'd2, A_SEC = 3'd3,
                         A_NEXT = 3'd4, A_CUR = 3'd5, A_STEP = 3'd6;

  logic [2:0]        op_q;
  logic [NS_W-1:0]   stg_ns, stg_next, stg_cur, ns_q, cur_q, next_q;
  logic [FRAC_W-1:0] stg_frac, frac_q;
  logic [SEC_W-1:0]  stg_sec, sec_q;
  logic [STEP_W-1:0] step_q;
  logic [63:0]       evt_q;

  logic [ACC_W-1:0]  acc_adv, delta, acc_cand;
  logic [NS_W-1:0]   cand_ns;

  assign acc_adv = {ns_q, frac_q} + ACC_W'(step_q);
  assign delta   = {stg_ns, stg_frac};

  always_comb begin
    case (op_q)
      OP_INC:  acc_cand = acc_adv + delta;
      OP_DEC:  acc_cand = (acc_adv > delta) ? acc_adv - delta : '0;
      default: acc_cand = acc_adv;
    endcase
  end

  assign cand_ns   = acc_cand[ACC_W-1:FRAC_W];
  assign now_ns    = ns_q;
  assign now_sec   = sec_q;
  assign evt_stamp = evt_q;
  assign cap_bits  = 64'd1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_q     <= '0;
      stg_ns   <= '0;
      stg_frac <= '0;
      stg_sec  <= '0;
      stg_cur  <= '0;
      stg_next <= ROLL;
      step_q   <= STEP_W'(STEP_RST);
      ns_q     <= '0;
      frac_q   <= '0;
      sec_q    <= '0;
      cur_q    <= '0;
      next_q   <= ROLL;
      evt_q    <= '0;
    end else begin
      op_q <= (wr_en && wr_addr == A_CTRL) ? wr_data[28:26] : 3'd0;
      if (wr_en) begin
        case (wr_addr)
          A_NS:    stg_ns   <= wr_data[NS_W-1:0];
          A_FRAC:  stg_frac <= wr_data[FRAC_W-1:0];
          A_SEC:   stg_sec  <= wr_data[SEC_W-1:0];
          A_NEXT:  stg_next <= wr_data[NS_W-1:0];
          A_CUR:   stg_cur  <= wr_data[NS_W-1:0];
          A_STEP:  step_q   <= wr_data[STEP_W-1:0];
          default: ;
        endcase
      end
      if (evt_strobe)
        evt_q <= {sec_q[31:0], 32'(ns_q - cur_q)};
      if (op_q == OP_SET) begin
        ns_q   <= stg_ns;
        frac_q <= stg_frac;
        sec_q  <= stg_sec;
        next_q <= stg_next;
        cur_q  <= stg_cur;
      end else begin
        {ns_q, frac_q} <= acc_cand;
        if (cand_ns >= next_q) begin
          sec_q  <= sec_q + 1'b1;
          cur_q  <= next_q;
          next_q <= next_q + ROLL;
        end else if (cand_ns < cur_q) begin
          sec_q  <= sec_q - 1'b1;
          next_q <= cur_q;
          cur_q  <= cur_q - ROLL;
        end
      end
    end
  end

  assert_op_selfclear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_q != 3'd0 && !(wr_en && wr_addr == A_CTRL)) |=> op_q == 3'd0);

  assert_set_loads_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_q == OP_SET) |=> (ns_q == $past(stg_ns) && sec_q == $past(stg_sec)
                          && next_q == $past(stg_next) && cur_q == $past(stg_cur)));

  assert_sec_single_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_q != OP_SET) |=> (sec_q == $past(sec_q) || sec_q == $past(sec_q) + 1'b1
                          || sec_q == $past(sec_q) - 1'b1));

  assert_free_run_forward_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (op_q == 3'd0 || op_q == OP_INC) |=> ns_q >= $past(ns_q));

  assert_dec_no_gain_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_q == OP_DEC) |=> ns_q <= $past(ns_q) + NS_W'($past(step_q) >> FRAC_W) + 1'b1);
endmodule

// File: tb/tod_atomic_clock_tb.sv
`timescale 1ns/1ps
module tod_atomic_clock_tb_top;
  localparam logic [63:0] SEC = 64'd1_000_000_000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [2:0]  wr_addr;
  logic [63:0] wr_data;
  logic        evt_strobe;
  logic [63:0] now_ns, now_sec, evt_stamp, cap_bits;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  tod_atomic_clock dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .evt_strobe(evt_strobe), .now_ns(now_ns), .now_sec(now_sec),
    .evt_stamp(evt_stamp), .cap_bits(cap_bits));

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [63:0] d);
    wr_addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic [63:0] exp_adj(input logic [63:0] n0, input bit neg, input logic [63:0] d);
    logic [63:0] base = n0 + 64'd5;
    if (!neg) return base + d;
    return (base > d) ? base - d : 64'd0;
  endfunction

  task automatic do_set(input logic [63:0] t);
    wr(3'd1, t);
    wr(3'd2, 64'd0);
    wr(3'd3, t / SEC);
    wr(3'd4, (t / SEC + 1) * SEC);
    wr(3'd5, (t / SEC) * SEC);
    wr(3'd0, 64'd1 << 26);
    @(negedge clk);
    chk(now_ns == t, "R6 set ns", now_ns, t);
    chk(now_sec == t / SEC, "R6 set sec", now_sec, t / SEC);
  endtask

  task automatic do_adj(input bit neg, input logic [63:0] d);
    logic [63:0] n0, e;
    wr(3'd1, d);
    wr(3'd2, 64'd0);
    wr(3'd0, (neg ? 64'd4 : 64'd3) << 26);
    n0 = now_ns;
    e = exp_adj(n0, neg, d);
    @(negedge clk);
    chk(now_ns == e, neg ? "R8 dec ns" : "R7 inc ns", now_ns, e);
    chk(now_sec == e / SEC, neg ? "R8 dec sec" : "R7 inc sec", now_sec, e / SEC);
    @(negedge clk);
    chk(now_ns == e + 5, "R5 applied once", now_ns, e + 5);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [63:0] n0, s0, t, d;
    int unsigned seed_dummy;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; evt_strobe = 1'b0;
    seed_dummy = $urandom(32'h5eed_1234);
    repeat (3) @(negedge clk);
    chk(now_ns == 0, "R1 ns", now_ns, 0);
    chk(now_sec == 0, "R1 sec", now_sec, 0);
    chk(evt_stamp == 0, "R1 evt", evt_stamp, 0);
    chk(cap_bits[0] == 1'b1, "R11 cap", cap_bits, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(now_ns == 5, "R2 first tick", now_ns, 5);
    for (int i = 0; i < 4; i++) begin
      n0 = now_ns; @(negedge clk);
      chk(now_ns == n0 + 5, "R2 step", now_ns, n0 + 5);
    end

    wr(3'd1, 64'd12345);
    wr(3'd3, 64'd7);
    n0 = now_ns; @(negedge clk);
    chk(now_ns == n0 + 5, "R12 staging ignored ns", now_ns, n0 + 5);
    chk(now_sec == 0, "R12 staging ignored sec", now_sec, 0);

    wr(3'd0, 64'd2 << 26);
    n0 = now_ns; @(negedge clk);
    chk(now_ns == n0 + 5, "R5 unused code", now_ns, n0 + 5);
    wr(3'd0, 64'h0000_0000_E3FF_FFFF);
    n0 = now_ns; @(negedge clk);
    chk(now_ns == n0 + 5, "R5 other bits no effect", now_ns, n0 + 5);

    do_set(SEC - 12);
    for (int i = 0; i < 4; i++) begin
      n0 = now_ns; @(negedge clk);
      chk(now_ns == n0 + 5, "R4 step near edge", now_ns, n0 + 5);
      chk(now_sec == now_ns / SEC, "R4 rollover sec", now_sec, now_ns / SEC);
    end
    chk(now_sec == 1, "R4 crossed", now_sec, 1);
    do_set(5 * SEC - 3);
    n0 = now_ns; @(negedge clk);
    chk(now_sec == 5, "R4 second crossing", now_sec, 5);

    do_set(SEC - 100);
    do_adj(1'b0, 64'd200);
    do_set(2 * SEC + 50);
    do_adj(1'b1, 64'd300);
    do_set(64'd100);
    do_adj(1'b1, 64'd500);
    chk(now_sec == 0, "R9 saturate sec", now_sec, 0);

    do_set(64'd1000);
    wr(3'd6, 64'h0000_0002_8000_0000);
    for (int i = 0; i < 4; i++) begin
      n0 = now_ns; @(negedge clk);
      chk(now_ns - n0 == ((i % 2 == 0) ? 64'd2 : 64'd3), "R3 fractional carry",
          now_ns - n0, (i % 2 == 0) ? 64'd2 : 64'd3);
    end
    wr(3'd6, 64'h0000_0005_0000_0000);

    do_set(3 * SEC + 777);
    n0 = now_ns; s0 = now_sec;
    evt_strobe = 1'b1;
    @(negedge clk);
    evt_strobe = 1'b0;
    chk(evt_stamp[63:32] == s0[31:0], "R10 evt sec", {32'd0, evt_stamp[63:32]}, s0);
    chk({32'd0, evt_stamp[63:32]} * SEC + {32'd0, evt_stamp[31:0]} == n0, "R10 evt ns",
        {32'd0, evt_stamp[63:32]} * SEC + {32'd0, evt_stamp[31:0]}, n0);

    for (int i = 0; i < 30; i++) begin
      case ($urandom % 3)
        0: begin
          t = 64'($urandom % 16) * SEC + 64'($urandom % 1_000_000_000);
          do_set(t);
        end
        1: begin
          d = 64'($urandom % 1_000_000_000);
          do_adj(1'b0, d);
        end
        default: begin
          d = 64'($urandom % 1_000_000_000);
          do_adj(1'b1, d);
        end
      endcase
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule